// File: doc/BRIEF.md
# Debug Access Port Register Router

This block sits between a debugger's serial front end and a set of access ports inside the chip. Each access it receives carries a port/local select bit, a read/write bit, a two-bit word index and a 32-bit write value. Accesses with the select bit clear stay local and reach a small debug-port register bank. That bank holds an identification word and a selection register. Accesses with the select bit set go to one of `N_AP` access ports over a parallel request/response bus.

An access-port register cannot be named in a single access. The debugger first writes the selection register with a port number and a register bank. Every later access-port access then goes to that port, at the byte address formed from the stored bank and the word index of the access. A port number with no port behind it ends the access at once with an error. Only one access-port request is in flight at a time. The upstream handshake stays not-ready until the chosen port answers.

Top module: `dap_reg_router`

## Requirements
- R1: After reset the selection register reads as zero. No access-port request is active, and `acc_ready` is low while no access is presented.
- R2: A local write (`acc_ap`=0, `acc_rd`=0) with `acc_a`=2 loads the selection register, keeping only the port number in bits [31:24] and the bank in bits [7:4]. A local read with `acc_a`=2 returns that value, with every other bit zero.
- R3: A local read with `acc_a`=0 returns the parameter `DP_ID`. Local reads with `acc_a`=1 or 3 return zero. Local writes to word indices 0, 1 or 3 leave the selection register unchanged.
- R4: An access-port access (`acc_ap`=1) to a present port P = select[31:24] raises only `ap_req_valid[P]`. It presents `ap_req_addr` = {bank[3:0], acc_a[1:0], 2'b00}, so bank 1 with index 1 gives 0x14. It also presents the access's read flag and write data.
- R5: While a request is in flight, `acc_ready` stays low and the request outputs hold steady. In the cycle where port P raises `ap_rsp_valid[P]`, `acc_ready` goes high and carries that port's read data and error bit.
- R6: An access-port access whose port number is `N_AP` or above completes in the cycle it is presented. It gives `acc_err`=1 and `acc_rdata`=0, and it raises no request.
- R7: A response strobe from any port other than the one with the request in flight has no effect on the result or on the completion time.
- R8: Local accesses complete in the cycle they are presented, with `acc_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented; held until `acc_ready` |
| acc_ap | input | 1 | 1 = access-port register, 0 = local register |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_a | input | 2 | Word index (address bits 3:2) |
| acc_wdata | input | 32 | Write value |
| acc_ready | output | 1 | Access complete this cycle |
| acc_rdata | output | 32 | Read result, valid with `acc_ready` |
| acc_err | output | 1 | Error result, valid with `acc_ready` |
| ap_req_valid | output | N_AP | One-hot request strobe per port, held until answered |
| ap_req_rd | output | 1 | Request is a read |
| ap_req_addr | output | 8 | Port register byte address |
| ap_req_wdata | output | 32 | Request write value |
| ap_rsp_valid | input | N_AP | Per-port response strobe |
| ap_rsp_rdata | input | 32*N_AP | Per-port read data, port p at bits [32p+31:32p] |
| ap_rsp_err | input | N_AP | Per-port error bit |

## Verification
The bench goes after port numbers just past the last present port and far beyond it (3 and 255). A design with a loose range check would send a request to a missing port and hang, or alias onto port 0. Unselected ports drive stray response strobes with junk data throughout the run. A router that merged responses from all ports would finish early with the wrong word. Selection writes carry random junk in the reserved bits, and writes go to the other local indices. A bad mask or a loose address decode then shows up as a wrong read-back or a corrupted bank. Random port latencies, including zero, check that ready and the request stay consistent for the whole wait.

// File: rtl/dapr_pkg.sv
// Shared constants of the debug access port register router.
// Assumes a 32-bit register width fixed by the debug architecture.
package dapr_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [1:0]  IDX_ID    = 2'd0;
    localparam logic [1:0]  IDX_SEL   = 2'd2;
    localparam int unsigned PORT_LSB  = 24;
    localparam int unsigned BANK_LSB  = 4;
    // Bits of the selection register that store state; the rest read as zero.
    localparam logic [DW-1:0] SEL_KEEP = 32'hFF00_00F0;
endpackage

// File: rtl/dapr_dp_bank.sv
// Local debug-port register bank: selection register plus identification word.
// Assumes the caller qualifies wr_en with a local write to the selection index.
module dapr_dp_bank
    import dapr_pkg::*;
#(
    parameter logic [31:0] DP_ID = 32'h1BA0_1477
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    rd_idx,
    output logic [DW-1:0] rdata,
    output logic [7:0]    sel_port,
    output logic [3:0]    sel_bank
);
    logic [DW-1:0] sel_q;

    // Selection register: reset to zero, store only the defined fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wdata & SEL_KEEP;
    end

    // Read mux over the four local word indices.
    always_comb begin
        unique case (rd_idx)
            IDX_ID:  rdata = DP_ID;
            IDX_SEL: rdata = sel_q;
            default: rdata = '0;
        endcase
    end

    assign sel_port = sel_q[PORT_LSB +: 8];
    assign sel_bank = sel_q[BANK_LSB +: 4];

    // R2: a write lands in the register on the next edge, masked.
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sel_q == ($past(wdata) & SEL_KEEP));
    // R3: without a selection write the register holds.
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/dapr_ap_steer.sv
// Access-port request steering: captures one request, drives it to the chosen
// port, and returns that port's response. Assumes start only when not busy and
// only for a port index below N_AP.
module dapr_ap_steer
    import dapr_pkg::*;
#(
    parameter int unsigned N_AP = 3,
    localparam int unsigned IDXW = (N_AP > 1) ? $clog2(N_AP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDXW-1:0]      idx,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic [DW-1:0]        wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DW-1:0]        rdata,
    output logic                 err,
    output logic [N_AP-1:0]      ap_req_valid,
    output logic                 ap_req_rd,
    output logic [ADDR_W-1:0]    ap_req_addr,
    output logic [DW-1:0]        ap_req_wdata,
    input  logic [N_AP-1:0]      ap_rsp_valid,
    input  logic [N_AP*DW-1:0]   ap_rsp_rdata,
    input  logic [N_AP-1:0]      ap_rsp_err
);
    logic              busy_q;
    logic [IDXW-1:0]   idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rsp_word [N_AP];

    // Request capture and in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            idx_q   <= idx;
            addr_q  <= addr;
            rd_q    <= rd;
            wdata_q <= wdata;
        end else if (done) begin
            busy_q  <= 1'b0;
        end
    end

    // Per-port request strobe and response word unpacking.
    for (genvar g = 0; g < N_AP; g++) begin : g_port
        assign ap_req_valid[g] = busy_q && (int'(idx_q) == g);
        assign rsp_word[g]     = ap_rsp_rdata[g*DW +: DW];
    end

    assign busy         = busy_q;
    assign done         = busy_q && ap_rsp_valid[idx_q];
    assign rdata        = rsp_word[idx_q];
    assign err          = ap_rsp_err[idx_q];
    assign ap_req_rd    = rd_q;
    assign ap_req_addr  = addr_q;
    assign ap_req_wdata = wdata_q;

    // R4: never more than one port strobed.
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ap_req_valid));
    // R5: an unanswered request holds steady into the next cycle.
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ap_rsp_valid[idx_q]) |=>
            ($stable(ap_req_valid) && $stable(ap_req_addr) && $stable(ap_req_wdata) && $stable(ap_req_rd)));
endmodule

// File: rtl/dap_reg_router.sv
// Debug access port register router. Local accesses reach the debug-port bank;
// access-port accesses go to the port and bank held in the selection register.
// Assumes the upstream holds acc_valid and its fields until acc_ready.
module dap_reg_router
    import dapr_pkg::*;
#(
    parameter int unsigned N_AP  = 3,
    parameter logic [31:0] DP_ID = 32'h1BA0_1477,
    localparam int unsigned IDXW = (N_AP > 1) ? $clog2(N_AP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_ap,
    input  logic                 acc_rd,
    input  logic [1:0]           acc_a,
    input  logic [31:0]          acc_wdata,
    output logic                 acc_ready,
    output logic [31:0]          acc_rdata,
    output logic                 acc_err,
    output logic [N_AP-1:0]      ap_req_valid,
    output logic                 ap_req_rd,
    output logic [7:0]           ap_req_addr,
    output logic [31:0]          ap_req_wdata,
    input  logic [N_AP-1:0]      ap_rsp_valid,
    input  logic [N_AP*32-1:0]   ap_rsp_rdata,
    input  logic [N_AP-1:0]      ap_rsp_err
);
    logic [DW-1:0]     dp_rdata;
    logic [7:0]        sel_port;
    logic [3:0]        sel_bank;
    logic              busy, st_done, st_err;
    logic [DW-1:0]     st_rdata;
    logic              idle, dp_acc, ap_acc, absent, ap_start, sel_wr;

    // Access classification for the current cycle.
    assign idle     = !busy;
    assign dp_acc   = acc_valid && !acc_ap && idle;
    assign ap_acc   = acc_valid &&  acc_ap && idle;
    assign absent   = int'(sel_port) >= N_AP;
    assign ap_start = ap_acc && !absent;
    assign sel_wr   = dp_acc && !acc_rd && (acc_a == IDX_SEL);

    dapr_dp_bank #(.DP_ID(DP_ID)) i_dp_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr),
        .wdata    (acc_wdata),
        .rd_idx   (acc_a),
        .rdata    (dp_rdata),
        .sel_port (sel_port),
        .sel_bank (sel_bank)
    );

    dapr_ap_steer #(.N_AP(N_AP)) i_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (ap_start),
        .idx          (sel_port[IDXW-1:0]),
        .addr         ({sel_bank, acc_a, 2'b00}),
        .rd           (acc_rd),
        .wdata        (acc_wdata),
        .busy         (busy),
        .done         (st_done),
        .rdata        (st_rdata),
        .err          (st_err),
        .ap_req_valid (ap_req_valid),
        .ap_req_rd    (ap_req_rd),
        .ap_req_addr  (ap_req_addr),
        .ap_req_wdata (ap_req_wdata),
        .ap_rsp_valid (ap_rsp_valid),
        .ap_rsp_rdata (ap_rsp_rdata),
        .ap_rsp_err   (ap_rsp_err)
    );

    // Upstream completion and result selection.
    always_comb begin
        acc_ready = dp_acc || (ap_acc && absent) || st_done;
        acc_err   = (ap_acc && absent) || (st_done && st_err);
        if (dp_acc)
            acc_rdata = dp_acc && acc_rd ? dp_rdata : '0;
        else if (st_done)
            acc_rdata = st_rdata;
        else
            acc_rdata = '0;
    end

    // R5: no completion while the strobed port has not answered.
    a_r5_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ap_req_valid) && !(|(ap_req_valid & ap_rsp_valid))) |-> !acc_ready);
    // R6: a missing port never receives a request.
    a_r6_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ap && (ap_req_valid == '0) && absent) |=> (ap_req_valid == '0));
    // R8: local accesses never report an error.
    a_r8_dp_noerr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ap && acc_ready) |-> !acc_err);
    // R1: idle with nothing presented means no completion.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_ready);
endmodule

// File: tb/test_dap_reg_router.sv
module test_dap_reg_router;
    localparam int NP = 3;
    localparam logic [31:0] ID = 32'h1BA0_1477;
    localparam logic [31:0] KEEP = 32'hFF00_00F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_ap = 1'b0, acc_rd = 1'b0;
    logic [1:0] acc_a = '0;
    logic [31:0] acc_wdata = '0;
    logic acc_ready, acc_err;
    logic [31:0] acc_rdata;
    logic [NP-1:0] ap_req_valid;
    logic ap_req_rd;
    logic [7:0] ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic [NP-1:0] ap_rsp_valid = '0;
    logic [NP*32-1:0] ap_rsp_rdata = '0;
    logic [NP-1:0] ap_rsp_err = '0;

    int checks = 0, fails = 0;
    logic [31:0] sel_model = '0;
    logic [31:0] ref_mem [NP][64];
    logic [31:0] port_mem [NP][64];
    int lat [NP];
    int cnt [NP];
    bit active [NP];
    bit finished = 0;

    always #2 clk = ~clk;

    dap_reg_router #(.N_AP(NP), .DP_ID(ID)) i_dap_reg_router (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Port models: random latency, stray strobes on idle ports (R7 stimulus).
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            ap_rsp_valid[p] = 1'b0;
            ap_rsp_err[p]   = 1'b0;
            if (ap_req_valid[p] && !active[p]) begin
                active[p] = 1;
                cnt[p] = lat[p];
            end
            if (active[p]) begin
                if (cnt[p] == 0) begin
                    active[p] = 0;
                    ap_rsp_valid[p] = 1'b1;
                    if (p == 1 && ap_req_addr == 8'hFC) begin
                        ap_rsp_err[p] = 1'b1;
                        ap_rsp_rdata[p*32 +: 32] = '0;
                    end else if (ap_req_rd) begin
                        ap_rsp_rdata[p*32 +: 32] = port_mem[p][ap_req_addr[7:2]];
                    end else begin
                        port_mem[p][ap_req_addr[7:2]] = ap_req_wdata;
                        ap_rsp_rdata[p*32 +: 32] = 32'hBAD0_0000;
                    end
                end else begin
                    cnt[p]--;
                end
            end else if (!ap_req_valid[p] && ($urandom % 3 == 0)) begin
                ap_rsp_valid[p] = 1'b1;
                ap_rsp_err[p] = 1'($urandom);
                ap_rsp_rdata[p*32 +: 32] = $urandom;
            end
        end
    end

    function automatic logic [31:0] dp_expect(input logic [1:0] a);
        case (a)
            2'd0: return ID;
            2'd2: return sel_model;
            default: return 32'h0;
        endcase
    endfunction

    // One access with full checking against the bench model.
    task automatic access(input bit ap, input bit rd, input logic [1:0] a, input logic [31:0] wd);
        logic [31:0] got_d;
        logic got_e;
        int waits;
        int p;
        logic [7:0] eaddr;
        bit present;
        bit done;
        p = int'(sel_model[31:24]);
        present = ap && (p < NP);
        eaddr = {sel_model[7:4], a, 2'b00};
        for (int q = 0; q < NP; q++) lat[q] = $urandom % 4;
        @(negedge clk);
        acc_valid = 1; acc_ap = ap; acc_rd = rd; acc_a = a; acc_wdata = wd;
        waits = 0; done = 0;
        while (!done) begin
            #1;
            if (acc_ready) begin
                got_d = acc_rdata; got_e = acc_err; done = 1;
            end else if (present && waits > 0) begin
                chk(ap_req_valid == NP'(1 << p), "R4 req strobe", 32'(ap_req_valid), 32'(1 << p));
                chk(ap_req_addr == eaddr, "R4 req addr", 32'(ap_req_addr), 32'(eaddr));
                chk(ap_req_rd == rd, "R4 req rd", 32'(ap_req_rd), 32'(rd));
                if (!rd) chk(ap_req_wdata == wd, "R4 req wdata", ap_req_wdata, wd);
            end
            @(posedge clk);
            if (!done) begin
                @(negedge clk);
                waits++;
                if (waits > 40) begin
                    chk(0, "R5 watchdog", 32'(waits), 32'd40);
                    done = 1; got_d = '0; got_e = 0;
                end
            end
        end
        @(negedge clk);
        acc_valid = 0;
        if (!ap) begin
            chk(waits == 0, "R8 local completes at once", 32'(waits), 0);
            chk(got_e == 0, "R8 local no error", 32'(got_e), 0);
            if (rd) chk(got_d == dp_expect(a), a == 2 ? "R2 select read" : "R3 local read", got_d, dp_expect(a));
            else if (a == 2) sel_model = wd & KEEP;
        end else if (!present) begin
            chk(waits == 0 && got_e == 1, "R6 absent error", {31'(waits), got_e}, 32'h1);
            chk(got_d == 0, "R6 absent data", got_d, 0);
            chk(ap_req_valid == 0, "R6 no request", 32'(ap_req_valid), 0);
        end else begin
            chk(waits >= 1, "R5 waits for port", 32'(waits), 1);
            if (p == 1 && eaddr == 8'hFC) begin
                chk(got_e == 1 && got_d == 0, "R5 port error", {got_d[30:0], got_e}, 32'h1);
            end else begin
                chk(got_e == 0, "R7 err from selected port", 32'(got_e), 0);
                if (rd) chk(got_d == ref_mem[p][eaddr[7:2]], "R7 data from selected port", got_d, ref_mem[p][eaddr[7:2]]);
                else ref_mem[p][eaddr[7:2]] = wd;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin
            active[p] = 0; cnt[p] = 0; lat[p] = 0;
            for (int w = 0; w < 64; w++) begin ref_mem[p][w] = '0; port_mem[p][w] = '0; end
        end
        repeat (3) @(negedge clk);
        #1;
        chk(acc_ready == 0, "R1 idle not ready", 32'(acc_ready), 0);
        chk(ap_req_valid == 0, "R1 no request", 32'(ap_req_valid), 0);
        rst_n = 1;
        access(0, 1, 2'd2, 0);                    // R1 select reads zero
        access(0, 1, 2'd0, 0);                    // R3 id
        access(0, 0, 2'd2, 32'h01FF_FF1F);        // R2 select port 1 bank 1, junk masked
        access(0, 1, 2'd2, 0);
        access(1, 0, 2'd1, 32'hF000_0001);        // R4 offset 0x14
        access(1, 1, 2'd1, 0);
        access(0, 0, 2'd0, 32'hFFFF_FFFF);        // R3 writes elsewhere ignored
        access(0, 0, 2'd3, 32'hFFFF_FFFF);
        access(0, 1, 2'd2, 0);
        access(0, 0, 2'd2, 32'h0100_00F0);        // bank 15
        access(1, 1, 2'd3, 0);                    // port error at 0xFC
        access(0, 0, 2'd2, 32'h0300_0000);        // R6 first absent index
        access(1, 1, 2'd0, 0);
        access(0, 0, 2'd2, 32'hFF00_0000);        // R6 far index
        access(1, 0, 2'd2, 32'h1234_5678);
        for (int i = 0; i < 300; i++) begin
            int k = $urandom % 10;
            if (k < 2) begin
                logic [7:0] pp;
                int c = $urandom % 6;
                pp = (c < 4) ? 8'(c % 3) : (c == 4 ? 8'd3 : 8'(4 + $urandom % 252));
                access(0, 0, 2'd2, {pp, 16'($urandom), 4'($urandom), 4'($urandom)});
            end else if (k < 3) begin
                access(0, 1'($urandom), 2'($urandom), $urandom);
            end else begin
                access(1, 1'($urandom), 2'($urandom), $urandom);
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule